// File: doc/BRIEF.md
# Segment-Page Address Translator with Access Protection

This block maps a 20-bit logical address onto a 20-bit physical address through two table levels. The logical address holds a segment number, a page number and a word offset. A small fully associative translation buffer is searched first, keyed by segment and page. When the buffer misses, the block reads the segment's descriptor and then the page entry that gives the block number. The descriptor carries a page-table base, a length in pages and an access-rights code. A successful walk refills the buffer.

Both tables are register arrays inside the block, written through a simple configuration port. Each request is accepted when `req_ready` is high. The answer comes back as a one-cycle `rsp_valid` pulse. The pulse carries either the physical address or a fault code. The fault code reports a length violation, a write to read-only space, a data access to execute-only space, or a user access to system-only space.

Top module: `segpage_xlat`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0. Every segment descriptor holds length 0, so any request faults with code 1.
- R2: Logical address bits [19:16] are the segment, [15:8] the page and [7:0] the word. Physical address bits [19:8] are the block and [7:0] the word. The word field is copied unchanged.
- R3: On a buffer miss the page entry read is at index (descriptor base + page) mod 256, and its bits [11:0] give the block. `rsp_valid` rises two clocks after the accepting edge.
- R4: A successful walk stores its segment, page, block and rights in the buffer. A later request with the same segment and page is answered one clock after acceptance.
- R5: The buffer has 4 entries, filled in round-robin order. The fifth distinct fill replaces the oldest entry and leaves the other three intact.
- R6: When the page number is at or above the descriptor length, the response faults with code 1 and paddr 0. A faulted walk fills no buffer entry.
- R7: The rights codes are 0 read/write, 1 read only, 2 execute only and 3 system only. The access kinds are 0 read, 1 write and 2 fetch.
  - A write to read-only space faults with code 2.
  - A read or write to execute-only space faults with code 3.
  - A user-mode access to system-only space faults with code 4.
  - A supervisor access to system-only space is allowed, and so is a fetch from read-only space.
- R8: Rights are checked on buffer hits too, using the rights stored with the entry. The fault then arrives one clock after acceptance.
- R9: A length violation takes precedence over any rights violation.
- R10: Every configuration write invalidates all buffer entries. A page cached before the write is walked again and returns the newly written block.
- R11: `rsp_valid` lasts exactly one cycle. `req_ready` is 0 from the accepting edge until the response cycle, and a faulted response drives paddr 0.
- R12: With `cfg_sel`=0, a write goes to descriptor `cfg_addr[3:0]`: base in data[7:0], length in [16:8], rights in [18:17]. With `cfg_sel`=1, data[11:0] goes to page entry `cfg_addr[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the descriptor table, 1 the page table |
| cfg_addr | input | 8 | Table index |
| cfg_wdata | input | 19 | Entry contents |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_addr | input | 20 | Logical address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for user mode, 0 for supervisor |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a fault |
| rsp_code | output | 3 | 0 none, 1 length, 2 read-only, 3 execute-only, 4 system-only |
| rsp_paddr | output | 20 | Physical address, 0 on a fault |

## Verification
A corrupted buffer entry or replacement pointer shows at the ports as a wrong response latency: one clock where two were due, or the reverse. It can also show as a wrong block on the very next request to that page. The bench therefore tracks buffer contents in its own model and checks `rsp_valid` on every cycle of each request. A wrong descriptor or page-entry index shows within two clocks, as a wrong block or fault code. The wrap of base plus page, the length boundary and each rights combination are probed directly.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {ACC_RW = 2'd0, ACC_RO = 2'd1, ACC_XO = 2'd2, ACC_SYS = 2'd3} acc_t;
  typedef enum logic [1:0] {KIND_RD = 2'd0, KIND_WR = 2'd1, KIND_FETCH = 2'd2} kind_t;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0, FLT_LEN = 3'd1, FLT_RO = 3'd2, FLT_XO = 3'd3, FLT_SYS = 3'd4
  } fcode_t;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_LOOK = 2'd1, ST_WALK = 2'd2} xst_t;
endpackage

// File: rtl/xlat_acc_chk.sv
module xlat_acc_chk
  import xlat_pkg::*;
(
  input  logic [1:0] acc,
  input  logic [1:0] kind,
  input  logic       user,
  output logic [2:0] code
);
  always_comb begin
    code = FLT_NONE;
    case (acc)
      ACC_RO:  if (kind == KIND_WR) code = FLT_RO;
      ACC_XO:  if (kind != KIND_FETCH) code = FLT_XO;
      ACC_SYS: if (user) code = FLT_SYS;
      default: code = FLT_NONE;
    endcase
  end
endmodule

// File: rtl/xlat_tables.sv
module xlat_tables #(
  parameter int SEG_W = 4,
  parameter int PT_AW = 8,
  parameter int LEN_W = 9,
  parameter int BLK_W = 12,
  parameter int CFG_W = 19,
  parameter int CA_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CA_W-1:0]  cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [SEG_W-1:0] seg_idx,
  input  logic [PT_AW-1:0] pt_idx,
  output logic [PT_AW-1:0] seg_base,
  output logic [LEN_W-1:0] seg_len,
  output logic [1:0]       seg_acc,
  output logic [BLK_W-1:0] pt_blk
);
  localparam int SEG_N = 1 << SEG_W;
  localparam int PT_N  = 1 << PT_AW;

  logic [PT_AW-1:0] base_q [SEG_N];
  logic [LEN_W-1:0] len_q  [SEG_N];
  logic [1:0]       acc_q  [SEG_N];
  logic [BLK_W-1:0] blk_q  [PT_N];
  logic             seg_we, pt_we;

  assign seg_we = cfg_we & ~cfg_sel;
  assign pt_we  = cfg_we & cfg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SEG_N; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
        acc_q[i]  <= '0;
      end
    end else if (seg_we) begin
      base_q[cfg_addr[SEG_W-1:0]] <= cfg_wdata[PT_AW-1:0];
      len_q[cfg_addr[SEG_W-1:0]]  <= cfg_wdata[PT_AW +: LEN_W];
      acc_q[cfg_addr[SEG_W-1:0]]  <= cfg_wdata[PT_AW+LEN_W +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PT_N; i++) blk_q[i] <= '0;
    end else if (pt_we) begin
      blk_q[cfg_addr[PT_AW-1:0]] <= cfg_wdata[BLK_W-1:0];
    end
  end

  assign seg_base = base_q[seg_idx];
  assign seg_len  = len_q[seg_idx];
  assign seg_acc  = acc_q[seg_idx];
  assign pt_blk   = blk_q[pt_idx];
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 8,
  parameter int BLK_W  = 12,
  parameter int N      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEG_W-1:0]  lk_seg,
  input  logic [PAGE_W-1:0] lk_page,
  output logic              hit,
  output logic [BLK_W-1:0]  hit_blk,
  output logic [1:0]        hit_acc,
  input  logic              fill_en,
  input  logic [BLK_W-1:0]  fill_blk,
  input  logic [1:0]        fill_acc,
  input  logic              flush
);
  localparam int KEY_W = SEG_W + PAGE_W;
  localparam int PW    = (N > 1) ? $clog2(N) : 1;

  logic [KEY_W-1:0] key_q [N];
  logic [BLK_W-1:0] blk_q [N];
  logic [1:0]       acc_q [N];
  logic [N-1:0]     vld_q, vld_d;
  logic [PW-1:0]    ptr_q, ptr_d;
  logic [N-1:0]     hit_vec;
  logic [KEY_W-1:0] key;
  logic             do_fill;

  assign key     = {lk_seg, lk_page};
  assign do_fill = fill_en & ~flush;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (key_q[g] == key);
  end

  always_comb begin
    hit_blk = '0;
    hit_acc = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        hit_blk = hit_blk | blk_q[i];
        hit_acc = hit_acc | acc_q[i];
      end
    end
  end
  assign hit = |hit_vec;

  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (flush) begin
      vld_d = '0;
    end else if (do_fill) begin
      vld_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == PW'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        key_q[i] <= '0;
        blk_q[i] <= '0;
        acc_q[i] <= '0;
      end
    end else if (do_fill) begin
      key_q[ptr_q] <= key;
      blk_q[ptr_q] <= fill_blk;
      acc_q[ptr_q] <= fill_acc;
    end
  end

  // R5
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !hit);
endmodule

// File: rtl/segpage_xlat.sv
module segpage_xlat
  import xlat_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 8,
  parameter int WORD_W = 8,
  parameter int BLK_W  = 12,
  parameter int PT_AW  = 8,
  parameter int TLB_N  = 4,
  localparam int LA_W  = SEG_W + PAGE_W + WORD_W,
  localparam int PA_W  = BLK_W + WORD_W,
  localparam int LEN_W = PAGE_W + 1,
  localparam int CFG_W = (PT_AW + LEN_W + 2 > BLK_W) ? PT_AW + LEN_W + 2 : BLK_W,
  localparam int CA_W  = (PT_AW > SEG_W) ? PT_AW : SEG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CA_W-1:0]  cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LA_W-1:0]  req_addr,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [2:0]       rsp_code,
  output logic [PA_W-1:0]  rsp_paddr
);
  xst_t             st_q, st_d;
  logic [LA_W-1:0]  rq_addr_q;
  logic [1:0]       rq_kind_q;
  logic             rq_user_q;
  logic             rsp_valid_q, rsp_valid_d;
  logic             rsp_fault_q, rsp_fault_d;
  logic [2:0]       rsp_code_q, rsp_code_d;
  logic [PA_W-1:0]  rsp_paddr_q, rsp_paddr_d;
  logic             accept, fill_en, len_bad;

  logic [SEG_W-1:0]  rq_seg;
  logic [PAGE_W-1:0] rq_page;
  logic [WORD_W-1:0] rq_word;
  logic [PT_AW-1:0]  seg_base, pt_idx;
  logic [LEN_W-1:0]  seg_len;
  logic [1:0]        seg_acc, hit_acc;
  logic [BLK_W-1:0]  pt_blk, hit_blk;
  logic              tlb_hit;
  logic [2:0]        hit_code, walk_code;

  assign rq_seg  = rq_addr_q[LA_W-1 -: SEG_W];
  assign rq_page = rq_addr_q[WORD_W +: PAGE_W];
  assign rq_word = rq_addr_q[WORD_W-1:0];
  assign pt_idx  = seg_base + PT_AW'(rq_page);
  assign len_bad = (LEN_W'(rq_page) >= seg_len);

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  xlat_tables #(
    .SEG_W(SEG_W), .PT_AW(PT_AW), .LEN_W(LEN_W), .BLK_W(BLK_W), .CFG_W(CFG_W), .CA_W(CA_W)
  ) u_tables (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .seg_idx(rq_seg), .pt_idx(pt_idx), .seg_base(seg_base),
    .seg_len(seg_len), .seg_acc(seg_acc), .pt_blk(pt_blk)
  );

  xlat_tlb #(.SEG_W(SEG_W), .PAGE_W(PAGE_W), .BLK_W(BLK_W), .N(TLB_N)) u_tlb (
    .clk(clk), .rst_n(rst_n), .lk_seg(rq_seg), .lk_page(rq_page), .hit(tlb_hit),
    .hit_blk(hit_blk), .hit_acc(hit_acc), .fill_en(fill_en), .fill_blk(pt_blk),
    .fill_acc(seg_acc), .flush(cfg_we)
  );

  xlat_acc_chk u_hit_chk (.acc(hit_acc), .kind(rq_kind_q), .user(rq_user_q), .code(hit_code));
  xlat_acc_chk u_walk_chk (.acc(seg_acc), .kind(rq_kind_q), .user(rq_user_q), .code(walk_code));

  always_comb begin
    st_d        = st_q;
    rsp_valid_d = 1'b0;
    rsp_fault_d = rsp_fault_q;
    rsp_code_d  = rsp_code_q;
    rsp_paddr_d = rsp_paddr_q;
    fill_en     = 1'b0;
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_LOOK;
      ST_LOOK: begin
        if (tlb_hit) begin
          rsp_valid_d = 1'b1;
          st_d        = ST_IDLE;
          if (hit_code != FLT_NONE) begin
            rsp_fault_d = 1'b1;
            rsp_code_d  = hit_code;
            rsp_paddr_d = '0;
          end else begin
            rsp_fault_d = 1'b0;
            rsp_code_d  = FLT_NONE;
            rsp_paddr_d = {hit_blk, rq_word};
          end
        end else begin
          st_d = ST_WALK;
        end
      end
      ST_WALK: begin
        rsp_valid_d = 1'b1;
        st_d        = ST_IDLE;
        if (len_bad) begin
          rsp_fault_d = 1'b1;
          rsp_code_d  = FLT_LEN;
          rsp_paddr_d = '0;
        end else if (walk_code != FLT_NONE) begin
          rsp_fault_d = 1'b1;
          rsp_code_d  = walk_code;
          rsp_paddr_d = '0;
        end else begin
          rsp_fault_d = 1'b0;
          rsp_code_d  = FLT_NONE;
          rsp_paddr_d = {pt_blk, rq_word};
          fill_en     = ~cfg_we;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      rsp_valid_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_addr_q <= '0;
      rq_kind_q <= '0;
      rq_user_q <= 1'b0;
    end else if (accept) begin
      rq_addr_q <= req_addr;
      rq_kind_q <= req_kind;
      rq_user_q <= req_user;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_fault_q <= 1'b0;
      rsp_code_q  <= '0;
      rsp_paddr_q <= '0;
    end else if (rsp_valid_d) begin
      rsp_fault_q <= rsp_fault_d;
      rsp_code_q  <= rsp_code_d;
      rsp_paddr_q <= rsp_paddr_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_fault = rsp_fault_q;
  assign rsp_code  = rsp_code_q;
  assign rsp_paddr = rsp_paddr_q;

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid);
  // R11
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R11
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
  // R2
  word_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[WORD_W-1:0] == rq_word));
  // R7
  code_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_code != 3'd0)));
endmodule

// File: tb/sim_segpage_xlat.sv
`timescale 1ns/1ps
module sim_segpage_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [18:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_user = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [2:0]  rsp_code;
  logic [19:0] rsp_paddr;

  int tests = 0, failed = 0;
  bit done = 0;

  int m_base [16];
  int m_len  [16];
  int m_acc  [16];
  int m_pt   [256];
  int t_key [4];
  int t_blk [4];
  int t_acc [4];
  bit t_vld [4];
  int t_ptr = 0;

  always #2.5 clk = ~clk;

  segpage_xlat u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_kind(req_kind), .req_user(req_user), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_code(rsp_code), .rsp_paddr(rsp_paddr)
  );

  task automatic check(string rq, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int rights(int acc, int kind, bit user);
    if (acc == 1 && kind == 1) return 2;
    if (acc == 2 && kind != 2) return 3;
    if (acc == 3 && user) return 4;
    return 0;
  endfunction

  task automatic flush_model();
    for (int i = 0; i < 4; i++) t_vld[i] = 0;
  endtask

  task automatic wr_seg(int seg, int base, int len, int acc);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 0; cfg_addr = 8'(seg);
    cfg_wdata = 19'((acc << 17) | (len << 8) | base);
    @(negedge clk);
    cfg_we = 0;
    m_base[seg] = base; m_len[seg] = len; m_acc[seg] = acc;
    flush_model();
  endtask

  task automatic wr_pt(int idx, int blk);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 1; cfg_addr = 8'(idx); cfg_wdata = 19'(blk);
    @(negedge clk);
    cfg_we = 0;
    m_pt[idx] = blk;
    flush_model();
  endtask

  task automatic do_req(int seg, int page, int word, int kind, bit user, string rq);
    int key, hit_i, lat, code, pa;
    key = seg * 256 + page;
    hit_i = -1;
    for (int i = 0; i < 4; i++) if (t_vld[i] && t_key[i] == key) hit_i = i;
    if (hit_i >= 0) begin
      lat = 2;
      code = rights(t_acc[hit_i], kind, user);
      pa = (code != 0) ? 0 : t_blk[hit_i] * 256 + word;
    end else begin
      lat = 3;
      if (page >= m_len[seg]) code = 1;
      else code = rights(m_acc[seg], kind, user);
      pa = 0;
      if (code == 0) begin
        pa = m_pt[(m_base[seg] + page) % 256] * 256 + word;
        t_key[t_ptr] = key; t_blk[t_ptr] = pa / 256; t_acc[t_ptr] = m_acc[seg];
        t_vld[t_ptr] = 1; t_ptr = (t_ptr + 1) % 4;
      end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = 20'((seg << 16) | (page << 8) | word);
    req_kind = 2'(kind); req_user = user;
    for (int n = 1; n <= lat; n++) begin
      @(negedge clk);
      if (n == 1) begin
        req_valid = 0;
        check("R11", "ready while busy", int'(req_ready), 0);
      end
      if (n < lat) check(rq, "early rsp_valid (latency)", int'(rsp_valid), 0);
      else begin
        check(rq, "rsp_valid at expected cycle", int'(rsp_valid), 1);
        check(rq, "fault flag", int'(rsp_fault), int'(code != 0));
        check(rq, "fault code", int'(rsp_code), code);
        check(rq, "paddr", int'(rsp_paddr), pa);
      end
    end
    @(negedge clk);
    check("R11", "pulse width", int'(rsp_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_len[i] = 0; m_acc[i] = 0; end
    for (int i = 0; i < 256; i++) m_pt[i] = 0;
    flush_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "ready after reset", int'(req_ready), 1);
    check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    do_req(0, 0, 8'h11, 0, 0, "R1");

    wr_seg(2, 8'h10, 4, 0);
    wr_seg(5, 8'hF8, 16, 1);
    wr_seg(7, 8'h40, 256, 2);
    wr_seg(9, 8'h80, 2, 3);
    for (int i = 0; i < 4; i++) wr_pt(8'h10 + i, 12'h100 + i);
    wr_pt(8'h02, 12'hABC);
    wr_pt(8'h42, 12'h555);
    wr_pt(8'h80, 12'h777);

    do_req(2, 1, 8'h5A, 0, 1, "R3");
    do_req(2, 1, 8'hC3, 0, 1, "R4");
    do_req(2, 1, 8'h00, 1, 1, "R2");
    do_req(2, 3, 8'hFF, 0, 1, "R6");
    do_req(2, 4, 8'h01, 0, 1, "R6");
    do_req(2, 4, 8'h01, 0, 1, "R6");
    do_req(5, 8'h0A, 8'h33, 0, 1, "R3");
    do_req(5, 8'h0A, 8'h34, 1, 1, "R8");
    do_req(5, 8'h0A, 8'h35, 2, 1, "R7");
    do_req(7, 2, 8'h77, 2, 1, "R7");
    do_req(7, 2, 8'h78, 0, 1, "R8");
    do_req(9, 0, 8'h09, 0, 1, "R7");
    do_req(9, 0, 8'h0A, 0, 0, "R7");
    do_req(9, 0, 8'h0B, 1, 1, "R8");
    do_req(5, 8'h20, 8'h01, 1, 1, "R9");
    do_req(9, 2, 8'h01, 0, 1, "R9");
    do_req(2, 0, 8'h44, 0, 0, "R5");
    do_req(2, 1, 8'h45, 0, 0, "R5");
    do_req(7, 2, 8'h46, 2, 0, "R5");
    do_req(9, 0, 8'h47, 0, 0, "R5");
    wr_pt(8'h11, 12'h3C3);
    do_req(2, 1, 8'h99, 0, 0, "R10");
    do_req(2, 1, 8'h9A, 0, 0, "R10");
    wr_seg(4'hF, 8'h10, 1, 0);
    do_req(15, 0, 8'h21, 1, 1, "R12");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule